// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two eight-bit bidirectional buses, A and B. It can pass data between them in either direction, and it keeps one storage register for each direction. Each bus appears at the block edge as three vectors: the value sampled from the bus, the value the block drives, and a per-bit output enable. A pad ring or a bus-resolution wrapper combines them. For each direction, a select input chooses what the driven bus carries: live data taken from the opposite bus, or the contents of that direction's register.

The A-to-B register samples the resolved A bus on the rising edge of its own capture clock. The B-to-A register samples the resolved B bus on the rising edge of a second, separate capture clock. Both registers load whatever the select and enable inputs are set to.

Both directions can be enabled in live mode at the same time. Each bus would then echo the other, which forms a combinational loop. A hold register on the system clock removes the loop. It follows the resolved A bus value whenever that loop mode is not active, and both buses are driven from this copy while the loop mode is active.

A parameter selects an inverting variant. It complements every value the block drives and is otherwise identical.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On a rising edge of `cap_ab_clk` with `rst` low, the A-to-B register loads the resolved A bus value, whatever the select and enable inputs are. The resolved value is the driven value when the A side is driven, and `a_in` otherwise.
- R2: On a rising edge of `cap_ba_clk` with `rst` low, the B-to-A register loads the resolved B bus value, whatever the select and enable inputs are.
- R3: `pick_ab` = 0 makes the driven B bus carry live A data. `pick_ab` = 1 makes it carry the A-to-B register. `pick_ba` does the same for the A bus, choosing between live B data and the B-to-A register.
- R4: `drv_b` = 1 drives the B bus and `drv_a_n` = 0 drives the A bus. While driven, every bit of that bus's enable vector is 1. While not driven, the enable vector is all 0 and the output vector is all 0.
- R5: With `drv_b` = 0 and `drv_a_n` = 1, both output enables and both output vectors are all 0.
- R6: With both sides driven and both selects at 0, both buses carry the hold copy: A shows it unchanged and B shows it (complemented when inverting). The outputs stay constant while this mode lasts, whatever `a_in` and `b_in` do.
- R7: A capture edge on a driven bus's register stores the value the block is driving on that bus.
- R8: With `INVERT` = 1, every driven value (live, stored or held) is complemented relative to the non-inverting variant.
- R9: While `rst` is high, a capture edge clears that register to 0 and a system-clock edge clears the hold copy to 0.
- R10: On each `clk` edge outside the R6 mode, the hold copy loads the resolved A bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the hold copy |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab_clk | input | 1 | Capture clock of the A-to-B register |
| cap_ba_clk | input | 1 | Capture clock of the B-to-A register |
| pick_ab | input | 1 | B-side source: 0 live, 1 stored |
| pick_ba | input | 1 | A-side source: 0 live, 1 stored |
| drv_b | input | 1 | Drive B bus, active high |
| drv_a_n | input | 1 | Drive A bus, active low |
| a_in | input | DATA_W | Value seen on the A bus |
| a_out | output | DATA_W | Value driven onto the A bus |
| a_oe | output | DATA_W | A bus per-bit output enable |
| b_in | input | DATA_W | Value seen on the B bus |
| b_out | output | DATA_W | Value driven onto the B bus |
| b_oe | output | DATA_W | B bus per-bit output enable |

## Verification
Selects, enables and live data reach the outputs in the same cycle, with no register in the path. A capture edge changes the stored value at once, and the stored-mode output changes with it.

The hold copy is the only result that lags: it takes the resolved A value one `clk` edge after that value settles. The bench therefore changes inputs on a falling edge of `clk` and fires any capture pulse within the same low phase. It waits two full `clk` periods, so that the hold copy has updated at least once, and re-resolves the bus model before sampling.

The loop-mode vectors always follow a vector that drove a known A value. The expected held value therefore comes from the previous step of the table.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_B_ONLY = 2'd1,
      MODE_A_ONLY = 2'd2,
      MODE_BOTH   = 2'd3
   } drive_mode_e;

   function automatic drive_mode_e decode_mode(input logic drv_b, input logic drv_a_n);
      drive_mode_e m;
      unique case ({~drv_a_n, drv_b})
         2'b00:   m = MODE_IDLE;
         2'b01:   m = MODE_B_ONLY;
         2'b10:   m = MODE_A_ONLY;
         default: m = MODE_BOTH;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              cap_clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge cap_clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R9: reset edge leaves the register cleared
   p_rst_clear_r9: assert property (@(posedge cap_clk) rst |=> (q == '0));

   // R1 (and R2 for the second instance): the edge loads the resolved bus
   p_capture_r1: assert property (@(posedge cap_clk) disable iff (rst)
      $past(!rst) |-> (q == $past(d)));

endmodule

// File: rtl/xcvr_hold.sv
`timescale 1ns/1ps
module xcvr_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              freeze,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (!freeze) q <= d;
   end

   // R10: outside the loop mode the copy follows the resolved A bus
   p_track_r10: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !freeze) |-> (q == $past(d)));

   // R6: inside the loop mode the copy does not move
   p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && freeze) |-> $stable(q));

endmodule

// File: rtl/xcvr_side.sv
`timescale 1ns/1ps
module xcvr_side #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          INVERT   = 1'b0,
   parameter bit          HOLD_INV = 1'b0
) (
   input  logic              drv_self,
   input  logic              drv_other,
   input  logic              sel_self,
   input  logic              sel_other,
   input  logic [DATA_W-1:0] own_in,
   input  logic [DATA_W-1:0] other_in,
   input  logic [DATA_W-1:0] own_reg,
   input  logic [DATA_W-1:0] other_reg,
   input  logic [DATA_W-1:0] hold_val,
   output logic [DATA_W-1:0] res,
   output logic [DATA_W-1:0] bus_out,
   output logic [DATA_W-1:0] bus_oe
);

   logic [DATA_W-1:0] own_reg_f;
   logic [DATA_W-1:0] other_in_f;
   logic [DATA_W-1:0] hold_f;

   generate
      if (INVERT) begin : g_inv_path
         assign own_reg_f  = ~own_reg;
         assign other_in_f = ~other_in;
      end else begin : g_true_path
         assign own_reg_f  = own_reg;
         assign other_in_f = other_in;
      end
      if (HOLD_INV) begin : g_inv_hold
         assign hold_f = ~hold_val;
      end else begin : g_true_hold
         assign hold_f = hold_val;
      end
   endgenerate

   // Opposite bus driven from its register: two path flips cancel, so the
   // raw register value appears here.
   always_comb begin
      if (!drv_self)       res = own_in;
      else if (sel_self)   res = own_reg_f;
      else if (!drv_other) res = other_in_f;
      else if (sel_other)  res = other_reg;
      else                 res = hold_f;
   end

   assign bus_out = drv_self ? res : '0;
   assign bus_oe  = {DATA_W{drv_self}};

endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          INVERT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_ab_clk,
   input  logic              cap_ba_clk,
   input  logic              pick_ab,
   input  logic              pick_ba,
   input  logic              drv_b,
   input  logic              drv_a_n,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic [DATA_W-1:0] b_oe
);

   localparam logic [DATA_W-1:0] FLIP_MASK = {DATA_W{INVERT}};

   generate
      if (DATA_W < 1 || DATA_W > 4096) begin : g_bad_width
         $error("dual_reg_xcvr: DATA_W must lie in 1..4096");
      end
   endgenerate

   drive_mode_e       mode;
   logic              a_drv, b_drv, loop_mode;
   logic [DATA_W-1:0] reg_ab, reg_ba, hold_q;
   logic [DATA_W-1:0] a_res, b_res;

   assign mode      = decode_mode(drv_b, drv_a_n);
   assign a_drv     = (mode == MODE_A_ONLY) || (mode == MODE_BOTH);
   assign b_drv     = (mode == MODE_B_ONLY) || (mode == MODE_BOTH);
   assign loop_mode = (mode == MODE_BOTH) && !pick_ab && !pick_ba;

   xcvr_store #(.DATA_W(DATA_W)) u_store_ab (
      .cap_clk(cap_ab_clk), .rst(rst), .d(a_res), .q(reg_ab)
   );

   xcvr_store #(.DATA_W(DATA_W)) u_store_ba (
      .cap_clk(cap_ba_clk), .rst(rst), .d(b_res), .q(reg_ba)
   );

   xcvr_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst(rst), .freeze(loop_mode), .d(a_res), .q(hold_q)
   );

   xcvr_side #(.DATA_W(DATA_W), .INVERT(INVERT), .HOLD_INV(1'b0)) u_side_a (
      .drv_self(a_drv), .drv_other(b_drv),
      .sel_self(pick_ba), .sel_other(pick_ab),
      .own_in(a_in), .other_in(b_in),
      .own_reg(reg_ba), .other_reg(reg_ab),
      .hold_val(hold_q),
      .res(a_res), .bus_out(a_out), .bus_oe(a_oe)
   );

   xcvr_side #(.DATA_W(DATA_W), .INVERT(INVERT), .HOLD_INV(INVERT)) u_side_b (
      .drv_self(b_drv), .drv_other(a_drv),
      .sel_self(pick_ab), .sel_other(pick_ba),
      .own_in(b_in), .other_in(a_in),
      .own_reg(reg_ab), .other_reg(reg_ba),
      .hold_val(hold_q),
      .res(b_res), .bus_out(b_out), .bus_oe(b_oe)
   );

   // R4: each enable vector switches as a whole
   always_comb begin
      p_oe_uniform_r4: assert ((a_oe == '0) || (a_oe == '1) || $isunknown(a_oe));
      p_oe_uniform_b_r4: assert ((b_oe == '0) || (b_oe == '1) || $isunknown(b_oe));
   end

   // R5: idle leaves both buses undriven
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_IDLE) |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

   // R6 and R8: in the loop mode the two sides mirror each other
   p_loop_mirror_r6: assert property (@(posedge clk) disable iff (rst)
      loop_mode |-> ((a_out ^ b_out) == FLIP_MASK));

   // R6: held outputs stay put while the loop mode lasts
   p_loop_stable_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(loop_mode) && loop_mode && $past(!rst)) |-> $stable(a_out));

endmodule

// File: tb/test_dual_reg_xcvr.sv
`timescale 1ns/1ps
module test_dual_reg_xcvr;

   typedef struct packed {
      logic       sab, sba, ben, aenn;
      logic [7:0] ea, eb;
      logic       cab, cba;
      logic [7:0] eao;
      logic       eaoe;
      logic [7:0] ebo;
      logic       eboe;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,1'b1, 8'h3C,8'hA5, 1'b1,1'b1, 8'h00,1'b0, 8'h00,1'b0}, // R5 R1 R2 idle capture
      '{1'b0,1'b0,1'b1,1'b1, 8'h5A,8'h00, 1'b0,1'b0, 8'h00,1'b0, 8'h5A,1'b1}, // R3 R4 B live
      '{1'b1,1'b0,1'b1,1'b1, 8'h11,8'h00, 1'b0,1'b0, 8'h00,1'b0, 8'h3C,1'b1}, // R3 B stored
      '{1'b0,1'b0,1'b0,1'b0, 8'h00,8'h77, 1'b0,1'b0, 8'h77,1'b1, 8'h00,1'b0}, // R3 R4 A live
      '{1'b0,1'b1,1'b0,1'b0, 8'h00,8'h77, 1'b0,1'b0, 8'hA5,1'b1, 8'h00,1'b0}, // R3 A stored
      '{1'b0,1'b1,1'b0,1'b0, 8'h00,8'h42, 1'b0,1'b1, 8'h42,1'b1, 8'h00,1'b0}, // R2 load while A stored
      '{1'b0,1'b0,1'b1,1'b1, 8'h96,8'h00, 1'b1,1'b1, 8'h00,1'b0, 8'h96,1'b1}, // R7 capture driven B
      '{1'b1,1'b0,1'b1,1'b1, 8'h0F,8'h00, 1'b1,1'b0, 8'h00,1'b0, 8'h0F,1'b1}, // R1 load while B stored
      '{1'b0,1'b1,1'b0,1'b0, 8'h00,8'h55, 1'b0,1'b0, 8'h96,1'b1, 8'h00,1'b0}, // R7 check B-to-A reg
      '{1'b1,1'b1,1'b1,1'b0, 8'h00,8'h00, 1'b0,1'b0, 8'h96,1'b1, 8'h0F,1'b1}, // R3 both stored
      '{1'b1,1'b0,1'b1,1'b0, 8'h00,8'h00, 1'b0,1'b0, 8'h0F,1'b1, 8'h0F,1'b1}, // R3 mixed
      '{1'b0,1'b0,1'b1,1'b1, 8'hC3,8'h00, 1'b0,1'b0, 8'h00,1'b0, 8'hC3,1'b1}, // R10 prime hold
      '{1'b0,1'b0,1'b1,1'b0, 8'h00,8'hFF, 1'b0,1'b0, 8'hC3,1'b1, 8'hC3,1'b1}, // R6 R10 loop
      '{1'b0,1'b0,1'b1,1'b0, 8'h12,8'h34, 1'b0,1'b0, 8'hC3,1'b1, 8'hC3,1'b1}, // R6 inputs ignored
      '{1'b0,1'b0,1'b1,1'b0, 8'h12,8'h34, 1'b1,1'b1, 8'hC3,1'b1, 8'hC3,1'b1}, // R7 capture in loop
      '{1'b1,1'b0,1'b1,1'b1, 8'h00,8'h00, 1'b0,1'b0, 8'h00,1'b0, 8'hC3,1'b1}  // R7 show captured hold
   };

   logic       clk = 1'b0, rst = 1'b0, cap_ab_clk = 1'b0, cap_ba_clk = 1'b0;
   logic       pick_ab = 1'b0, pick_ba = 1'b0, drv_b = 1'b0, drv_a_n = 1'b1;
   logic [7:0] ext_a = '0, ext_b = '0;
   logic [7:0] a_in = '0, b_in = '0, a_out, a_oe, b_out, b_oe;
   logic [7:0] ai_in = '0, bi_in = '0, ai_out, ai_oe, bi_out, bi_oe;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   dual_reg_xcvr #(.DATA_W(8), .INVERT(1'b0)) i_dual_reg_xcvr (
      .clk(clk), .rst(rst), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
      .pick_ab(pick_ab), .pick_ba(pick_ba), .drv_b(drv_b), .drv_a_n(drv_a_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   dual_reg_xcvr #(.DATA_W(8), .INVERT(1'b1)) i_dual_reg_xcvr_inv (
      .clk(clk), .rst(rst), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
      .pick_ab(pick_ab), .pick_ba(pick_ba), .drv_b(drv_b), .drv_a_n(drv_a_n),
      .a_in(ai_in), .a_out(ai_out), .a_oe(ai_oe),
      .b_in(bi_in), .b_out(bi_out), .b_oe(bi_oe)
   );

   // resolved-bus model: a driven bus carries the block's value, else the external one
   task automatic settle();
      repeat (3) begin
         #0.2;
         a_in  = (a_oe  & a_out)  | (~a_oe  & ext_a);
         b_in  = (b_oe  & b_out)  | (~b_oe  & ext_b);
         ai_in = (ai_oe & ai_out) | (~ai_oe & ext_a);
         bi_in = (bi_oe & bi_out) | (~bi_oe & ext_b);
      end
   endtask

   task automatic apply(input logic sab, sba, ben, aenn, input logic [7:0] ea, eb,
                        input logic cab, cba);
      @(negedge clk);
      pick_ab = sab; pick_ba = sba; drv_b = ben; drv_a_n = aenn;
      ext_a = ea; ext_b = eb;
      settle();
      if (cab || cba) begin
         cap_ab_clk = cab; cap_ba_clk = cba;
         #0.5;
         cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
      end
      settle();
      @(negedge clk);
      @(negedge clk);
      settle();
   endtask

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset with the controls already in loop mode and the captures pulsed
      @(negedge clk);
      rst = 1'b1; drv_b = 1'b1; drv_a_n = 1'b0; pick_ab = 1'b0; pick_ba = 1'b0;
      ext_a = 8'hAA; ext_b = 8'h55;
      settle();
      repeat (2) begin
         cap_ab_clk = 1'b1; cap_ba_clk = 1'b1; #0.5;
         cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
         @(negedge clk);
      end
      rst = 1'b0;
      @(negedge clk); @(negedge clk);
      settle();
      chk("R9 reset hold a_out", a_out, 8'h00);
      chk("R9 reset hold b_out", b_out, 8'h00);
      chk("R4 a_oe driven", a_oe, 8'hFF);
      chk("R4 b_oe driven", b_oe, 8'hFF);
      apply(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'hA5, 1'b0, 1'b0);
      chk("R9 reset reg_ba via a_out", a_out, 8'h00);
      chk("R9 reset reg_ab via b_out", b_out, 8'h00);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].sab, VECS[i].sba, VECS[i].ben, VECS[i].aenn,
               VECS[i].ea, VECS[i].eb, VECS[i].cab, VECS[i].cba);
         chk($sformatf("R3 table %0d a_out", i), a_out, VECS[i].eao);
         chk($sformatf("R4 table %0d a_oe", i), a_oe, {8{VECS[i].eaoe}});
         chk($sformatf("R3 table %0d b_out", i), b_out, VECS[i].ebo);
         chk($sformatf("R4 table %0d b_oe", i), b_oe, {8{VECS[i].eboe}});
      end

      // R8: inverting variant after a fresh reset
      @(negedge clk);
      rst = 1'b1; drv_b = 1'b0; drv_a_n = 1'b1;
      cap_ab_clk = 1'b1; cap_ba_clk = 1'b1; #0.5;
      cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b0);
      chk("R8 inverted live B", bi_out, 8'hA5);
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
      chk("R8 R6 inverted loop a_out", ai_out, 8'h5A);
      chk("R8 R6 inverted loop b_out", bi_out, 8'hA5);
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 1'b1, 1'b0);
      chk("R5 inverted idle b_out", bi_out, 8'h00);
      apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
      chk("R8 R1 inverted stored B", bi_out, 8'hF0);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h33, 1'b0, 1'b0);
      chk("R8 inverted live A", ai_out, 8'hCC);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule